// File: doc/BRIEF.md
# Long Conditional Branch Unit

This block resolves one long relative branch at a time. The issuing logic presents a 16-bit branch opcode, a signed 16-bit displacement and the four condition flags (negative, zero, overflow, carry) together with a start request. The block checks that the opcode belongs to the long-branch group. It evaluates the condition selected by the low opcode nibble against the flags and, when the branch is taken, adds the sign-extended displacement to the 20-bit extended program address formed by a 4-bit bank field above a 16-bit program counter.

The bank and program counter live in the block and are cleared by reset. A taken branch occupies six cycles and a branch that is not taken occupies four. The cycle that presents the start request counts as the first of them. A one-cycle done pulse marks the last cycle. The new address and the taken flag are visible in that cycle. The condition flags are only read and never written. Advancing the program counter past a branch that is not taken is left to the surrounding logic.

Top module: `long_branch_unit`

## Requirements
- R1: A start accepted while idle whose opcode bits 15:4 differ from 0x378 raises `illegalOut` in the following cycle only. It leaves the bank and program counter unchanged, produces no done pulse, leaves the block idle and clears `takenOut`.
- R2: For a legal opcode, the condition is chosen by opcode bits 3:0 with flags N, Z, V, C. The even codes are true when: 0x0 always, 0x2 C|Z=0, 0x4 C=0, 0x6 Z=0, 0x8 V=0, 0xA N=0, 0xC N^V=0, 0xE Z|(N^V)=0. Each odd code is the complement of the even code just below it, so 0x1 is never and 0xD is N^V=1. `takenOut` shows the result.
- R3: On a taken branch, {bank, PC} becomes ({bank, PC} + sign-extended displacement) modulo 2^20. The new value appears in the done cycle, and the address does not move while the branch is busy.
- R4: A carry out of the 16-bit PC increments the bank, and a borrow decrements it. A borrow below bank 0 wraps to bank 0xF.
- R5: On a branch that is not taken, the bank and PC keep their values.
- R6: Counting the clock edge that accepts the start, done is high in the fifth cycle after that edge for a taken branch and in the third for one not taken. This makes the whole branch 6 or 4 cycles including the request cycle.
- R7: `done` is high for exactly one cycle. `busy` is high in every cycle between acceptance and the done cycle, and low in the done cycle.
- R8: Start requests presented while busy or in the done cycle are ignored. They set no illegal flag and change neither the address nor the branch in progress.
- R9: The flags and displacement are sampled on the accepting edge; later changes to them do not alter the result. `takenOut` holds until the next start.
- R10: A synchronous reset clears the bank, PC, busy state, done, taken and illegal outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Request to start a branch, taken only when idle |
| opcode | input | 16 | Branch opcode |
| offset | input | 16 | Signed relative displacement |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| pkOut | output | 4 | Bank field of the extended address |
| pcOut | output | 16 | Program counter |
| takenOut | output | 1 | Condition result of the last accepted branch |
| illegalOut | output | 1 | One-cycle flag for a rejected opcode |
| donePulse | output | 1 | High in the final cycle of a branch |
| busy | output | 1 | A branch is in progress |

## Verification
Several behaviours are checked by assertions on every cycle: the cycle count from acceptance to done for both outcomes, the single-cycle done pulse, busy running into done, the address holding while busy and on a not-taken result, the side-effect-free illegal response, and the state after reset. The truth of each of the sixteen conditions, the exact 20-bit sum, and bank carry, borrow and wrap can only be shown by the bench's scenarios. The same holds for ignoring stray requests and for sampling the flags at acceptance. The bench drives every code against every flag combination and steers the address across bank edges.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FIN  = 2'd2
  } lbrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // legal start taken in idle
    logic reject;  // illegal start seen in idle
    logic commit;  // last busy cycle: write address
  } lbrStrobes_t;

  // condition of the even member of pair sel; odd member is its complement
  function automatic logic pairBase(input logic [2:0] sel, input logic n,
                                    input logic z, input logic v, input logic c);
    logic r;
    case (sel)
      3'd0: r = 1'b1;
      3'd1: r = ~(c | z);
      3'd2: r = ~c;
      3'd3: r = ~z;
      3'd4: r = ~v;
      3'd5: r = ~n;
      3'd6: r = ~(n ^ v);
      default: r = ~(z | (n ^ v));
    endcase
    return r;
  endfunction

endpackage

// File: rtl/branch_cond.sv
module branch_cond #(
  parameter int OPC_W = 16,
  parameter logic [OPC_W-5:0] OPC_PREFIX = 12'h378
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagV,
  input  logic             flagC,
  output logic             condTrue,
  output logic             opLegal
);
  import lbr_pkg::*;

  localparam int PAIRS = 8;

  logic [PAIRS-1:0] pairVal;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pairVal[k] = pairBase(3'(k), flagN, flagZ, flagV, flagC);
  end

  assign condTrue = pairVal[opcode[3:1]] ^ opcode[0];
  assign opLegal  = (opcode[OPC_W-1:4] == OPC_PREFIX);
endmodule

// File: rtl/branch_ctrl.sv
module branch_ctrl #(
  parameter int TAKEN_CYCLES     = 6,
  parameter int NOT_TAKEN_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startValid,
  input  logic                 opLegal,
  input  logic                 condTrue,
  output lbr_pkg::lbrStrobes_t strobes,
  output logic                 busy,
  output logic                 donePulse
);
  import lbr_pkg::*;

  // busy spans cycles 2..N-1; counter loaded with N-3 at acceptance
  localparam int MAX_CYC = (TAKEN_CYCLES > NOT_TAKEN_CYCLES) ? TAKEN_CYCLES : NOT_TAKEN_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_TAKEN = CNT_W'(TAKEN_CYCLES - 3);
  localparam logic [CNT_W-1:0] LOAD_NOT   = CNT_W'(NOT_TAKEN_CYCLES - 3);

  lbrState_t      state;
  logic [CNT_W-1:0] cnt;
  logic           isIdle;

  assign isIdle = (state == ST_IDLE);

  always_comb begin
    strobes.accept = isIdle && startValid && opLegal;
    strobes.reject = isIdle && startValid && !opLegal;
    strobes.commit = (state == ST_BUSY) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobes.accept) begin
            state <= ST_BUSY;
            cnt   <= condTrue ? LOAD_TAKEN : LOAD_NOT;
          end
        end
        ST_BUSY: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_BUSY);
  assign donePulse = (state == ST_FIN);
endmodule

// File: rtl/branch_datapath.sv
module branch_datapath #(
  parameter int PK_W = 4,
  parameter int PC_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lbr_pkg::lbrStrobes_t strobes,
  input  logic                 condTrue,
  input  logic [PC_W-1:0]      offset,
  output logic [PK_W-1:0]      pkOut,
  output logic [PC_W-1:0]      pcOut,
  output logic                 takenOut,
  output logic                 illegalOut
);
  localparam int ADDR_W = PK_W + PC_W;

  logic [PC_W-1:0]   offsetReg;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] nextAddr;

  assign offExt   = {{PK_W{offsetReg[PC_W-1]}}, offsetReg};
  assign nextAddr = {pkOut, pcOut} + offExt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkOut      <= '0;
      pcOut      <= '0;
      offsetReg  <= '0;
      takenOut   <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      illegalOut <= strobes.reject;
      if (strobes.accept) begin
        offsetReg <= offset;
        takenOut  <= condTrue;
      end else if (strobes.reject) begin
        takenOut  <= 1'b0;
      end
      if (strobes.commit && takenOut) begin
        {pkOut, pcOut} <= nextAddr;
      end
    end
  end
endmodule

// File: rtl/long_branch_unit.sv
module long_branch_unit #(
  parameter int PK_W             = 4,
  parameter int PC_W             = 16,
  parameter int OPC_W            = 16,
  parameter logic [OPC_W-5:0] OPC_PREFIX = 12'h378,
  parameter int TAKEN_CYCLES     = 6,
  parameter int NOT_TAKEN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [PC_W-1:0]  offset,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagV,
  input  logic             flagC,
  output logic [PK_W-1:0]  pkOut,
  output logic [PC_W-1:0]  pcOut,
  output logic             takenOut,
  output logic             illegalOut,
  output logic             donePulse,
  output logic             busy
);
  import lbr_pkg::*;

  lbrStrobes_t strobes;
  logic        condTrue;
  logic        opLegal;

  branch_cond #(.OPC_W(OPC_W), .OPC_PREFIX(OPC_PREFIX)) i_cond (
    .opcode(opcode), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .condTrue(condTrue), .opLegal(opLegal)
  );

  branch_ctrl #(.TAKEN_CYCLES(TAKEN_CYCLES), .NOT_TAKEN_CYCLES(NOT_TAKEN_CYCLES)) i_ctrl (
    .clk(clk), .rst(rst), .startValid(startValid), .opLegal(opLegal),
    .condTrue(condTrue), .strobes(strobes), .busy(busy), .donePulse(donePulse)
  );

  branch_datapath #(.PK_W(PK_W), .PC_W(PC_W)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .condTrue(condTrue), .offset(offset),
    .pkOut(pkOut), .pcOut(pcOut), .takenOut(takenOut), .illegalOut(illegalOut)
  );
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
  parameter int PK_W             = 4,
  parameter int PC_W             = 16,
  parameter int OPC_W            = 16,
  parameter logic [OPC_W-5:0] OPC_PREFIX = 12'h378,
  parameter int TAKEN_CYCLES     = 6,
  parameter int NOT_TAKEN_CYCLES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             startValid,
  input logic [OPC_W-1:0] opcode,
  input logic [PK_W-1:0]  pkOut,
  input logic [PC_W-1:0]  pcOut,
  input logic             takenOut,
  input logic             illegalOut,
  input logic             donePulse,
  input logic             busy
);
  logic [7:0] cyc;
  logic       acceptSeen;

  assign acceptSeen = startValid && !busy && !donePulse && (opcode[OPC_W-1:4] == OPC_PREFIX);

  always_ff @(posedge clk) begin
    if (rst)             cyc <= '0;
    else if (acceptSeen) cyc <= 8'd2;
    else if (donePulse)  cyc <= '0;
    else if (cyc != '0)  cyc <= cyc + 8'd1;
  end

  p_cycles_r6: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> (cyc == (takenOut ? 8'(TAKEN_CYCLES) : 8'(NOT_TAKEN_CYCLES))));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

  p_busy_to_done_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || donePulse));

  p_addr_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable({pkOut, pcOut}));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (donePulse && !takenOut) |-> $stable({pkOut, pcOut}));

  p_illegal_clean_r1: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> (!busy && !donePulse && !takenOut && $stable({pkOut, pcOut})));

  p_illegal_src_r1: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> $past(startValid && (opcode[OPC_W-1:4] != OPC_PREFIX)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (pkOut == '0 && pcOut == '0 && !busy && !donePulse && !takenOut && !illegalOut));
endmodule

bind long_branch_unit lbr_checker #(
  .PK_W(PK_W), .PC_W(PC_W), .OPC_W(OPC_W), .OPC_PREFIX(OPC_PREFIX),
  .TAKEN_CYCLES(TAKEN_CYCLES), .NOT_TAKEN_CYCLES(NOT_TAKEN_CYCLES)
) i_lbr_checker (
  .clk(clk), .rst(rst), .startValid(startValid), .opcode(opcode),
  .pkOut(pkOut), .pcOut(pcOut), .takenOut(takenOut), .illegalOut(illegalOut),
  .donePulse(donePulse), .busy(busy)
);

// File: tb/test_long_branch_unit.sv
module test_long_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] offset = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [3:0]  pkOut;
  logic [15:0] pcOut;
  logic        takenOut, illegalOut, donePulse, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [19:0] model = '0;

  always #10 clk = ~clk;

  long_branch_unit i_long_branch_unit (
    .clk(clk), .rst(rst), .startValid(startValid), .opcode(opcode), .offset(offset),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .pkOut(pkOut), .pcOut(pcOut), .takenOut(takenOut), .illegalOut(illegalOut),
    .donePulse(donePulse), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // flags packed as {N,Z,V,C}
  function automatic logic condModel(input logic [3:0] code, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (code)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !(c | z);
      4'h3: return c | z;
      4'h4: return !c;
      4'h5: return c;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return !v;
      4'h9: return v;
      4'hA: return !n;
      4'hB: return n;
      4'hC: return !(n ^ v);
      4'hD: return n ^ v;
      4'hE: return !(z | (n ^ v));
      default: return z | (n ^ v);
    endcase
  endfunction

  function automatic logic [19:0] addrModel(input logic [19:0] a, input logic [15:0] off);
    return a + {{4{off[15]}}, off};
  endfunction

  task automatic runBranch(input logic [3:0] code, input logic [15:0] off, input logic [3:0] f);
    logic        expTaken;
    logic [19:0] expAddr;
    int          lat;
    expTaken = condModel(code, f);
    expAddr  = expTaken ? addrModel(model, off) : model;
    @(negedge clk);
    startValid = 1'b1; opcode = {12'h378, code}; offset = off;
    {flagN, flagZ, flagV, flagC} = f;
    @(negedge clk);
    // R9 and R8: scramble inputs and keep requesting while busy
    opcode = 16'($urandom); offset = 16'($urandom);
    {flagN, flagZ, flagV, flagC} = 4'($urandom);
    lat = 1;
    while (!donePulse && lat < 10) begin
      check(busy === 1'b1, "R7 busy before done", 32'(busy), 1);
      @(negedge clk);
      lat++;
    end
    check(lat == (expTaken ? 5 : 3), "R6 done latency", lat, expTaken ? 5 : 3);
    check(busy === 1'b0, "R7 busy low in done cycle", 32'(busy), 0);
    check(takenOut === expTaken, "R2 R9 taken", 32'(takenOut), 32'(expTaken));
    if (expTaken)
      check({pkOut, pcOut} === expAddr, "R3 taken address", {pkOut, pcOut}, expAddr);
    else
      check({pkOut, pcOut} === expAddr, "R5 not-taken hold", {pkOut, pcOut}, expAddr);
    if (expTaken && expAddr[19:16] != model[19:16])
      check(pkOut === expAddr[19:16], "R4 bank change", pkOut, expAddr[19:16]);
    model = expAddr;
    @(negedge clk);
    check(donePulse === 1'b0, "R7 done one cycle", 32'(donePulse), 0);
    check(!busy && !illegalOut && {pkOut, pcOut} === model, "R8 stray start ignored",
          {busy, illegalOut, pkOut, pcOut}, {2'b00, model});
    startValid = 1'b0;
  endtask

  task automatic runIllegal(input logic [15:0] opc);
    @(negedge clk);
    startValid = 1'b1; opcode = opc; offset = 16'($urandom);
    @(negedge clk);
    startValid = 1'b0;
    check(illegalOut === 1'b1, "R1 illegal raised", 32'(illegalOut), 1);
    check(!busy && !donePulse && !takenOut && {pkOut, pcOut} === model, "R1 illegal no effect",
          {busy, donePulse, takenOut, pkOut, pcOut}, {3'b000, model});
    @(negedge clk);
    check(illegalOut === 1'b0, "R1 illegal one cycle", 32'(illegalOut), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({pkOut, pcOut, busy, donePulse, takenOut, illegalOut} === '0, "R10 reset state",
          {pkOut, pcOut}, 0);

    // R2: every code against every flag combination
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++)
        runBranch(4'(code), 16'($urandom), 4'(f));

    // R4: walk to a known address, then cross bank edges
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model = '0;
    check({pkOut, pcOut} === 20'h0, "R10 mid-run reset", {pkOut, pcOut}, 0);
    runBranch(4'h0, 16'hFFFF, 4'h0);   // borrow below bank 0 wraps to 0xF
    runBranch(4'h0, 16'h0001, 4'h0);   // carry back to bank 0
    runBranch(4'h0, 16'h7FFF, 4'h0);
    runBranch(4'h0, 16'h7FFF, 4'h0);
    runBranch(4'h0, 16'h0002, 4'h0);   // 0x0FFFE -> 0x10000
    runBranch(4'h0, 16'h8000, 4'h0);   // backward borrow into bank 0
    runBranch(4'h1, 16'h1234, 4'hF);   // never: hold

    // R1: illegal opcodes
    runIllegal(16'h3790);
    runIllegal(16'h377F);
    runIllegal(16'h0000);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] op;
      op = 16'($urandom);
      if (op[15:4] == 12'h378) op[15] = 1'b0;
      runIllegal(op);
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 7) == 0) runIllegal(16'h3700 | 16'($urandom_range(0, 127)));
      else runBranch(4'($urandom), 16'($urandom), 4'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule